// File: doc/BRIEF.md
# Switching Clock-Controlled Keystream Generator

This block produces a keystream one bit at a time from two shift registers. A small control register, stepped once per output bit, decides which of two feedback rules advances a larger data register for that bit. When the control bit is 0, the data register takes a key-defined number of single steps under the first polynomial. When it is 1, it takes a key-defined number of steps under the second polynomial. Both polynomials are primitive, distinct and of the same degree. The output bit is the top cell of the data register once the last step for that bit is done.

A user loads nonzero seeds for both registers, together with the two step counts that form the key. The generator then runs by itself. Each output bit takes as many clock cycles as its step count. A valid strobe marks the one cycle in which the bit may be taken, and a busy flag is high while a multi-step advance is under way.

Top module: `swg_gen`

## Requirements
- R1: While reset is asserted, and after reset until the first accepted load, ks_valid_o, ks_bit_o and busy_o are all low.
- R2: A load is accepted only if both seed_ctrl_i and seed_data_i are nonzero. A rejected load has no effect: a running keystream continues exactly as if no load had been requested, and an idle block stays idle.
- R3: An accepted load replaces both register states and the key, and abandons any advance in progress. The cycle after the load edge shows ks_valid_o and busy_o low. The first output bit then appears two cycles after the load edge when its step count is 1.
- R4: The control bit is cell 0 of the control register. Once per output bit, the control register steps by the companion rule: new cell 0 = c0·top, and new cell k = old cell k-1 XOR ck·top, where top is the old highest cell and bit k of a polynomial parameter holds the coefficient of x^k (the leading term is implicit).
- R5: If the control bit is 0, the data register takes key0 single steps under POLY0. If it is 1, it takes key1 single steps under POLY1. Both use the same companion rule as R4.
- R6: An output that needs k steps occupies k cycles. busy_o is high for the first k-1 of them, and ks_valid_o is high with busy_o low in the last. ks_valid_o and busy_o are never high together.
- R7: In a valid cycle, ks_bit_o equals the highest cell of the data register after the final step. ks_bit_o is low whenever ks_valid_o is low.
- R8: The key inputs are sampled only at an accepted load. Changes at other times have no effect on the keystream or its timing.
- R9: A key value of 0, or one above 2^DATA_W-2, is treated as 1.
- R10: With the default polynomials (x^2+x+1, x^3+x+1, x^3+x^2+1), control seed 2'b10, data seed 3'b100 and key (1, 6), the keystream starts 0, 1, 1 and repeats with period 21.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Request to load seeds and key |
| seed_ctrl_i | input | CTRL_W | Control register seed, bit k = cell k |
| seed_data_i | input | DATA_W | Data register seed, bit k = cell k |
| key0_i | input | DATA_W | Step count used when the control bit is 0 |
| key1_i | input | DATA_W | Step count used when the control bit is 1 |
| ks_bit_o | output | 1 | Keystream bit, qualified by ks_valid_o |
| ks_valid_o | output | 1 | One-cycle strobe marking a new keystream bit |
| busy_o | output | 1 | High while a multi-step advance is in progress |

## Verification
A wrong control register state first shows as a wrong choice of step count. That puts the next valid strobe one or more cycles early or late, which the per-cycle comparison catches within one output period. A wrong data register state, or a wrong polynomial, shows as a wrong keystream bit no later than the next valid strobe whose top cell differs. A miscounted step shows in the gap between strobes and also corrupts later bits. Loads that are wrongly accepted or rejected change the very next cycle of the valid and busy outputs.

// File: rtl/swg_pkg.sv
package swg_pkg;

  // One companion-matrix step on a register held in the low bits of a word:
  // shift up one cell, fold the polynomial in when the old top cell was set.
  function automatic logic [31:0] comp_step(input logic [31:0] s,
                                            input logic [31:0] poly,
                                            input logic [31:0] width_mask,
                                            input logic [31:0] top_mask);
    logic fb;
    fb = |(s & top_mask);
    return ((s << 1) & width_mask) ^ (fb ? (poly & width_mask) : 32'd0);
  endfunction

  // Out-of-range step counts collapse to a single step.
  function automatic logic [31:0] clamp_key(input logic [31:0] v,
                                            input logic [31:0] vmax);
    return (v == 32'd0 || v > vmax) ? 32'd1 : v;
  endfunction

endpackage

// File: rtl/swg_ctrl_lfsr.sv
module swg_ctrl_lfsr #(
  parameter int W = 2,
  parameter logic [W-1:0] POLY = 2'b11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] seed,
  input  logic         advance,
  output logic         ctl_bit,
  output logic [W-1:0] state_o
);
  import swg_pkg::*;

  localparam logic [31:0] WMASK = (W >= 32) ? 32'hFFFF_FFFF : ((32'd1 << W) - 32'd1);
  localparam logic [31:0] TOPM  = 32'd1 << (W - 1);

  logic [W-1:0] q;
  logic [W-1:0] nxt;

  assign nxt = W'(comp_step(32'(q), 32'(POLY), WMASK, TOPM));

  always_ff @(posedge clk) begin
    if (!rst_n)       q <= '0;
    else if (load)    q <= seed;
    else if (advance) q <= nxt;
  end

  assign ctl_bit = q[0];
  assign state_o = q;
endmodule

// File: rtl/swg_data_reg.sv
module swg_data_reg #(
  parameter int W = 3,
  parameter logic [W-1:0] POLY0 = 3'b011,
  parameter logic [W-1:0] POLY1 = 3'b101
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] seed,
  input  logic         step,
  input  logic         sel,
  output logic [W-1:0] state_o
);
  import swg_pkg::*;

  localparam logic [31:0] WMASK = (W >= 32) ? 32'hFFFF_FFFF : ((32'd1 << W) - 32'd1);
  localparam logic [31:0] TOPM  = 32'd1 << (W - 1);
  localparam logic [1:0][W-1:0] POLYS = {POLY1, POLY0};

  logic [W-1:0] q;
  logic [1:0][W-1:0] cand;

  // One candidate next state per feedback rule.
  for (genvar g = 0; g < 2; g++) begin : g_rule
    assign cand[g] = W'(comp_step(32'(q), 32'(POLYS[g]), WMASK, TOPM));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= seed;
    else if (step) q <= cand[sel];
  end

  assign state_o = q;
endmodule

// File: rtl/swg_step_seq.sv
module swg_step_seq #(
  parameter int KW = 3,
  parameter int KMAX = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_ok,
  input  logic [KW-1:0] key0,
  input  logic [KW-1:0] key1,
  input  logic          ctl_bit,
  output logic          run_o,
  output logic          start_o,
  output logic          step_o,
  output logic          sel_o,
  output logic          done_o,
  output logic          busy_o,
  output logic [KW-1:0] cnt_o
);
  import swg_pkg::*;

  logic          run_q;
  logic          sel_q;
  logic [KW-1:0] cnt_q;
  logic [KW-1:0] k0_q;
  logic [KW-1:0] k1_q;
  logic [KW-1:0] k_now;

  // Every running cycle applies one single step; a zero count starts a bit.
  assign step_o  = run_q && !load_ok;
  assign start_o = step_o && (cnt_q == '0);
  assign k_now   = ctl_bit ? k1_q : k0_q;
  assign sel_o   = start_o ? ctl_bit : sel_q;
  assign done_o  = start_o ? (k_now == KW'(1)) : (step_o && cnt_q == KW'(1));
  assign busy_o  = run_q && (cnt_q != '0);
  assign run_o   = run_q;
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      sel_q <= 1'b0;
      cnt_q <= '0;
      k0_q  <= KW'(1);
      k1_q  <= KW'(1);
    end else if (load_ok) begin
      run_q <= 1'b1;
      cnt_q <= '0;
      k0_q  <= KW'(clamp_key(32'(key0), 32'(KMAX)));
      k1_q  <= KW'(clamp_key(32'(key1), 32'(KMAX)));
    end else if (start_o) begin
      sel_q <= ctl_bit;
      cnt_q <= k_now - KW'(1);
    end else if (step_o) begin
      cnt_q <= cnt_q - KW'(1);
    end
  end
endmodule

// File: rtl/swg_gen.sv
module swg_gen #(
  parameter int CTRL_W = 2,
  parameter int DATA_W = 3,
  parameter logic [CTRL_W-1:0] CTRL_POLY = 2'b11,
  parameter logic [DATA_W-1:0] POLY0 = 3'b011,
  parameter logic [DATA_W-1:0] POLY1 = 3'b101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [CTRL_W-1:0] seed_ctrl_i,
  input  logic [DATA_W-1:0] seed_data_i,
  input  logic [DATA_W-1:0] key0_i,
  input  logic [DATA_W-1:0] key1_i,
  output logic              ks_bit_o,
  output logic              ks_valid_o,
  output logic              busy_o
);
  localparam int KMAX = (2 ** DATA_W) - 2;

  // Named internal events, also watched by the bound checker.
  logic              load_ok_w;
  logic              start_w;
  logic              step_w;
  logic              sel_w;
  logic              done_w;
  logic              run_w;
  logic              ctl_bit_w;
  logic              busy_w;
  logic [DATA_W-1:0] cnt_w;
  logic [CTRL_W-1:0] ctrl_state_w;
  logic [DATA_W-1:0] data_state_w;
  logic              valid_q;

  assign load_ok_w = load_i && (|seed_ctrl_i) && (|seed_data_i);

  swg_ctrl_lfsr #(.W(CTRL_W), .POLY(CTRL_POLY)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load_ok_w),
    .seed    (seed_ctrl_i),
    .advance (start_w),
    .ctl_bit (ctl_bit_w),
    .state_o (ctrl_state_w)
  );

  swg_data_reg #(.W(DATA_W), .POLY0(POLY0), .POLY1(POLY1)) u_data (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load_ok_w),
    .seed    (seed_data_i),
    .step    (step_w),
    .sel     (sel_w),
    .state_o (data_state_w)
  );

  swg_step_seq #(.KW(DATA_W), .KMAX(KMAX)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_ok (load_ok_w),
    .key0    (key0_i),
    .key1    (key1_i),
    .ctl_bit (ctl_bit_w),
    .run_o   (run_w),
    .start_o (start_w),
    .step_o  (step_w),
    .sel_o   (sel_w),
    .done_o  (done_w),
    .busy_o  (busy_w),
    .cnt_o   (cnt_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= done_w;
  end

  // The data register holds still during the valid cycle.
  assign ks_valid_o = valid_q;
  assign ks_bit_o   = valid_q & data_state_w[DATA_W-1];
  assign busy_o     = busy_w;
endmodule

// File: rtl/swg_gen_chk.sv
module swg_gen_chk #(
  parameter int CTRL_W = 2,
  parameter int DATA_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load_ok,
  input logic              start,
  input logic              running,
  input logic              ks_bit,
  input logic              ks_valid,
  input logic              busy,
  input logic [CTRL_W-1:0] ctrl_state,
  input logic [DATA_W-1:0] data_state,
  input logic [DATA_W-1:0] cnt
);
  localparam int KMAX = (2 ** DATA_W) - 2;

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (!busy && !ks_valid));

  assert_seeds_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (data_state != '0 && ctrl_state != '0));

  assert_load_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_ok |=> (!ks_valid && !busy));

  assert_ctrl_moves_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (ctrl_state != $past(ctrl_state)));

  assert_valid_busy_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ks_valid |-> !busy);

  assert_busy_ends_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !$past(load_ok)) |-> ks_valid);

  assert_bit_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ks_valid |-> !ks_bit);

  assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(cnt) < KMAX));
endmodule

bind swg_gen swg_gen_chk #(.CTRL_W(CTRL_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .load_ok    (load_ok_w),
  .start      (start_w),
  .running    (run_w),
  .ks_bit     (ks_bit_o),
  .ks_valid   (ks_valid_o),
  .busy       (busy_o),
  .ctrl_state (ctrl_state_w),
  .data_state (data_state_w),
  .cnt        (cnt_w)
);

// File: tb/swg_gen_tb.sv
module swg_gen_tb;
  localparam int M = 2;
  localparam int N = 3;
  localparam logic [M-1:0] PA = 2'b11;
  localparam logic [N-1:0] P0 = 3'b011;
  localparam logic [N-1:0] P1 = 3'b101;
  localparam int KMAX = 6;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load_i = 1'b0;
  logic [M-1:0] seed_ctrl_i = '0;
  logic [N-1:0] seed_data_i = '0;
  logic [N-1:0] key0_i = '0;
  logic [N-1:0] key1_i = '0;
  logic         ks_bit_o, ks_valid_o, busy_o;

  swg_gen #(.CTRL_W(M), .DATA_W(N), .CTRL_POLY(PA), .POLY0(P0), .POLY1(P1)) u_dut (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .seed_ctrl_i(seed_ctrl_i),
    .seed_data_i(seed_data_i), .key0_i(key0_i), .key1_i(key1_i),
    .ks_bit_o(ks_bit_o), .ks_valid_o(ks_valid_o), .busy_o(busy_o)
  );

  always #2 clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done_flag = 0;

  // Reference model: a queue of expected {valid, bit, busy} per cycle.
  logic [2:0]   q[$];
  logic [M-1:0] mA;
  logic [N-1:0] mB;
  int           mk0, mk1;
  bit           m_run = 0;
  bit           cap[$];
  int           capt[$];

  function automatic logic [N-1:0] ref_step_b(logic [N-1:0] s, logic [N-1:0] p);
    logic [N-1:0] r;
    r[0] = p[0] & s[N-1];
    for (int b = 1; b < N; b++) r[b] = s[b-1] ^ (p[b] & s[N-1]);
    return r;
  endfunction

  function automatic logic [M-1:0] ref_step_a(logic [M-1:0] s);
    logic [M-1:0] r;
    r[0] = PA[0] & s[M-1];
    for (int b = 1; b < M; b++) r[b] = s[b-1] ^ (PA[b] & s[M-1]);
    return r;
  endfunction

  function automatic int clampk(int v);
    return (v < 1 || v > KMAX) ? 1 : v;
  endfunction

  task automatic gen_group();
    logic c;
    int k;
    c = mA[0];
    mA = ref_step_a(mA);
    k = c ? mk1 : mk0;
    for (int s = 0; s < k; s++) mB = ref_step_b(mB, c ? P1 : P0);
    for (int s = 0; s < k - 1; s++) q.push_back(3'b001);
    q.push_back({1'b1, mB[N-1], 1'b0});
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      q.delete();
      m_run = 0;
    end else if (load_i && seed_ctrl_i != '0 && seed_data_i != '0) begin
      q.delete();
      q.push_back(3'b000);
      mA = seed_ctrl_i;
      mB = seed_data_i;
      mk0 = clampk(int'(key0_i));
      mk1 = clampk(int'(key1_i));
      m_run = 1;
    end else if (m_run) begin
      if (q.size() > 0) void'(q.pop_front());
      if (q.size() == 0) gen_group();
    end
  end

  // Per-cycle comparison against the model (R5, R6, R7).
  always @(negedge clk) begin
    logic [2:0] exp_v;
    logic [2:0] act_v;
    if (!done_flag) begin
      exp_v = (q.size() > 0) ? q[0] : 3'b000;
      act_v = {ks_valid_o, ks_bit_o, busy_o};
      n_vec++;
      if (act_v !== exp_v) begin
        n_bad++;
        $display("FAIL R5/R6/R7 cycle %0d: actual valid/bit/busy=%b expected %b", cyc, act_v, exp_v);
      end
      if (ks_valid_o) begin
        cap.push_back(ks_bit_o);
        capt.push_back(cyc);
      end
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int expv);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic drive_load(logic [M-1:0] c, logic [N-1:0] d, logic [N-1:0] k0, logic [N-1:0] k1);
    @(negedge clk);
    seed_ctrl_i = c; seed_data_i = d; key0_i = k0; key1_i = k1; load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
  endtask

  task automatic wait_outs(int n);
    int base;
    int t;
    base = cap.size();
    t = 0;
    while (cap.size() < base + n && t < 5000) begin
      @(negedge clk);
      t++;
    end
    chk(cap.size() >= base + n, "R6", "outputs produced", cap.size() - base, n);
  endtask

  task automatic gaps_in(int from, int a, int b, string req);
    int bad;
    int last;
    bad = 0;
    last = 0;
    for (int i = from + 1; i < cap.size(); i++) begin
      int g;
      g = capt[i] - capt[i-1];
      if (g != a && g != b) begin bad++; last = g; end
    end
    chk(bad == 0, req, "gap between strobes", last, a);
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL R6 watchdog expired: actual %0d cycles expected completion", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int from;
    int c0;
    bit diff7;
    repeat (4) @(negedge clk);
    chk(!ks_valid_o && !busy_o && !ks_bit_o, "R1", "outputs in reset", int'({ks_valid_o, busy_o, ks_bit_o}), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!ks_valid_o && !busy_o, "R1", "idle before load", int'({ks_valid_o, busy_o}), 0);

    // R2: zero data seed rejected while idle
    drive_load(2'b01, 3'b000, 3'd1, 3'd1);
    repeat (10) @(negedge clk);
    chk(cap.size() == 0 && !busy_o, "R2", "strobes after rejected load", cap.size(), 0);

    // R10: worked example
    drive_load(2'b10, 3'b100, 3'd1, 3'd6);
    cap.delete(); capt.delete();
    wait_outs(42);
    chk(cap[0] == 0, "R10", "bit 0", int'(cap[0]), 0);
    chk(cap[1] == 1, "R10", "bit 1", int'(cap[1]), 1);
    chk(cap[2] == 1, "R10", "bit 2", int'(cap[2]), 1);
    for (int i = 0; i < 21; i++)
      chk(cap[i] == cap[i+21], "R10", "period 21 repeat", int'(cap[i+21]), int'(cap[i]));
    diff7 = 0;
    for (int i = 0; i < 14; i++) if (cap[i] != cap[i+7]) diff7 = 1;
    chk(diff7, "R10", "not period 7", 0, 1);
    gaps_in(0, 1, 6, "R5");

    // R8: key inputs change without load
    key0_i = 3'd3; key1_i = 3'd2;
    from = cap.size();
    wait_outs(15);
    gaps_in(from, 1, 6, "R8");

    // R2: zero control seed rejected mid-run
    from = cap.size();
    drive_load(2'b00, 3'b101, 3'd2, 3'd2);
    wait_outs(10);
    gaps_in(from, 1, 6, "R2");

    // R9: keys 0 and 7 clamp to one step
    drive_load(2'b01, 3'b011, 3'd0, 3'd7);
    c0 = cyc;
    from = cap.size();
    wait_outs(12);
    chk(capt[from] == c0 + 1, "R3", "first strobe cycle", capt[from], c0 + 1);
    gaps_in(from, 1, 1, "R9");

    // R3: load in the middle of a long advance
    drive_load(2'b01, 3'b001, 3'd6, 3'd6);
    begin
      int t;
      t = 0;
      while (!busy_o && t < 100) begin @(negedge clk); t++; end
    end
    repeat (2) @(negedge clk);
    chk(busy_o, "R6", "busy mid-advance", int'(busy_o), 1);
    drive_load(2'b11, 3'b110, 3'd2, 3'd4);
    chk(!ks_valid_o && !busy_o, "R3", "after restart", int'({ks_valid_o, busy_o}), 0);
    from = cap.size();
    wait_outs(12);
    gaps_in(from, 2, 4, "R5");

    // R4/R6: keys (3,2) from another seed pair
    drive_load(2'b11, 3'b111, 3'd3, 3'd2);
    from = cap.size();
    wait_outs(20);
    gaps_in(from, 3, 2, "R4");

    repeat (3) @(negedge clk);
    done_flag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule